// File: doc/BRIEF.md
# ATM Cell Prefix and HEC Slot Inserter

This block sits in the transmit cell path, between the stage that assembles 53-byte ATM cells and the stage that serialises them. Each incoming cell is a byte stream of four header bytes, one HEC byte and 48 payload bytes. Per cell, the block can emit three connection-specific bytes ahead of the header. It can also substitute a connection-specific byte for the HEC byte. All other bytes pass through unchanged.

The connection-specific bytes are read from a per-connection descriptor through a byte-wide read port that has a fixed one-cycle latency. The descriptor offset comes from a steering value. Two enable inputs select the features. The block samples the enables and the steering value when a cell begins, fetches only the bytes that the cell needs, and holds its input ready low during that fetch. The output is a valid/ready byte stream with start-of-cell and end-of-cell markers.

Top module: `cell_prefix_inserter`

## Requirements
- R1: While reset is asserted, and after reset until the first input byte is offered, out_valid, out_sop, out_eop, desc_rd_en and in_ready all stay low.
- R2: When en_prefix is sampled high for a cell, the output cell is 56 bytes long. Its first three bytes are the descriptor bytes at offsets steer, steer+1 and steer+2, in that order. Offsets wrap modulo 2^DESC_AW.
- R3: When en_hec_swap is sampled high for a cell, output byte 4 of the ATM section (the HEC position, counting the header from 0) carries the descriptor byte at offset steer+3. The cell length does not change.
- R4: en_prefix, en_hec_swap and steer are sampled only in the cycle in which the first byte of a cell is offered while the block is idle. Changes later in the cell take effect from the next cell.
- R5: desc_rd_data is taken exactly one cycle after the matching desc_rd_en. desc_rd_en is never high while in_ready is high or while out_valid is high.
- R6: out_sop marks the first output byte of every cell, which is the first prefix byte when the prefix is on. out_eop marks the last payload byte. out_sop and out_eop are never high together.
- R7: While out_valid is high and out_ready is low, the next cycle keeps out_valid high with out_data, out_sop and out_eop unchanged. No byte is lost or repeated.
- R8: A cell with both enables low causes no descriptor read. A cell with one or both enables high causes exactly as many reads as bytes it uses: 3, 1 or 4.
- R9: All header and payload bytes, apart from a replaced HEC byte, appear at the output unchanged and in input order. With both enables low the output is identical to the input cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_prefix | input | 1 | Enable three-byte prefix ahead of the header |
| en_hec_swap | input | 1 | Enable replacement of the HEC byte |
| steer | input | DESC_AW | Descriptor offset of the first user byte |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DATA_W | Input cell byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| desc_rd_en | output | 1 | Descriptor read strobe |
| desc_rd_addr | output | DESC_AW | Descriptor byte offset |
| desc_rd_data | input | DATA_W | Descriptor byte, one cycle after the strobe |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DATA_W | Output byte |
| out_sop | output | 1 | First byte of an output cell |
| out_eop | output | 1 | Last byte of an output cell |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
The hardest case to reach is an enable or steering change in the middle of a cell while output backpressure stalls the prefix or the HEC slot, because it needs three things together: a cell already past its sampling point, a live fetch configuration, and a stalled output. The stimulus randomises the enables and steer value right after every first-byte handshake, and it drops out_ready at random on about a third of the cycles. Directed first cells cover each enable combination. They also cover a steer value near the top of the offset range, so that the descriptor offset wraps.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

    localparam int PREFIX_LEN = 3;
    localparam int USER_BYTES = 4;
    localparam int HEC_SLOT   = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_FETCH,
        SEQ_PREFIX,
        SEQ_BODY
    } seq_state_e;

endpackage

// File: rtl/cpi_desc_fetch.sv
module cpi_desc_fetch #(
    parameter  int DATA_W = 8,
    parameter  int AW     = 8,
    parameter  int NUSER  = 4,
    localparam int IW     = $clog2(NUSER)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [IW-1:0]                first_idx,
    input  logic [IW-1:0]                last_idx,
    input  logic [AW-1:0]                base,
    output logic                         rd_en,
    output logic [AW-1:0]                rd_addr,
    input  logic [DATA_W-1:0]            rd_data,
    output logic                         done,
    output logic [NUSER-1:0][DATA_W-1:0] user_bytes
);

    typedef struct packed {
        logic                         active;
        logic [IW-1:0]                idx;
        logic [IW-1:0]                last;
        logic                         pend;
        logic [IW-1:0]                pend_idx;
        logic [AW-1:0]                base;
        logic [NUSER-1:0][DATA_W-1:0] user;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.pend = 1'b0;
        rd_en   = 1'b0;
        done    = 1'b0;
        rd_addr = f_q.base + AW'(f_q.idx);

        // capture the byte requested in the previous cycle
        if (f_q.pend) begin
            f_d.user[f_q.pend_idx] = rd_data;
            if (f_q.pend_idx == f_q.last) begin
                done = 1'b1;
            end
        end

        if (start) begin
            f_d.active = 1'b1;
            f_d.idx    = first_idx;
            f_d.last   = last_idx;
            f_d.base   = base;
        end else if (f_q.active) begin
            rd_en        = 1'b1;
            f_d.pend     = 1'b1;
            f_d.pend_idx = f_q.idx;
            if (f_q.idx == f_q.last) begin
                f_d.active = 1'b0;
            end else begin
                f_d.idx = f_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign user_bytes = f_q.user;

endmodule

// File: rtl/cpi_out_mux.sv
module cpi_out_mux #(
    parameter  int DATA_W = 8,
    parameter  int NUSER  = 4,
    localparam int IW     = $clog2(NUSER)
) (
    input  logic                         prefix_phase,
    input  logic [IW-1:0]                prefix_idx,
    input  logic                         hec_slot,
    input  logic [NUSER-1:0][DATA_W-1:0] user_bytes,
    input  logic [DATA_W-1:0]            in_data,
    output logic [DATA_W-1:0]            out_data
);

    always_comb begin
        if (prefix_phase) begin
            out_data = user_bytes[prefix_idx];
        end else if (hec_slot) begin
            out_data = user_bytes[NUSER-1];
        end else begin
            out_data = in_data;
        end
    end

endmodule

// File: rtl/cell_prefix_inserter.sv
module cell_prefix_inserter
    import cpi_pkg::*;
#(
    parameter  int DATA_W   = 8,
    parameter  int DESC_AW  = 8,
    parameter  int CELL_LEN = 53,
    localparam int POS_W    = $clog2(CELL_LEN),
    localparam int IW       = $clog2(USER_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_prefix,
    input  logic               en_hec_swap,
    input  logic [DESC_AW-1:0] steer,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    output logic               desc_rd_en,
    output logic [DESC_AW-1:0] desc_rd_addr,
    input  logic [DATA_W-1:0]  desc_rd_data,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_sop,
    output logic               out_eop,
    input  logic               out_ready
);

    typedef struct packed {
        seq_state_e    state;
        logic          pre_on;
        logic          hec_on;
        logic [IW-1:0] pre_cnt;
        logic [POS_W-1:0] pos;
    } seq_t;

    seq_t s_d, s_q;

    logic                             fetch_start;
    logic [IW-1:0]                    fetch_first;
    logic [IW-1:0]                    fetch_last;
    logic                             fetch_done;
    logic [USER_BYTES-1:0][DATA_W-1:0] user_bytes;
    logic                             prefix_phase;
    logic                             hec_slot;

    always_comb begin
        s_d         = s_q;
        fetch_start = 1'b0;
        fetch_first = en_prefix ? IW'(0) : IW'(USER_BYTES - 1);
        fetch_last  = en_hec_swap ? IW'(USER_BYTES - 1) : IW'(PREFIX_LEN - 1);
        in_ready    = 1'b0;
        out_valid   = 1'b0;
        out_sop     = 1'b0;
        out_eop     = 1'b0;

        unique case (s_q.state)
            SEQ_IDLE: begin
                if (in_valid) begin
                    s_d.pre_on  = en_prefix;
                    s_d.hec_on  = en_hec_swap;
                    s_d.pre_cnt = '0;
                    s_d.pos     = '0;
                    if (en_prefix || en_hec_swap) begin
                        fetch_start = 1'b1;
                        s_d.state   = SEQ_FETCH;
                    end else begin
                        s_d.state = SEQ_BODY;
                    end
                end
            end
            SEQ_FETCH: begin
                if (fetch_done) begin
                    s_d.state = s_q.pre_on ? SEQ_PREFIX : SEQ_BODY;
                end
            end
            SEQ_PREFIX: begin
                out_valid = 1'b1;
                out_sop   = (s_q.pre_cnt == '0);
                if (out_ready) begin
                    if (s_q.pre_cnt == IW'(PREFIX_LEN - 1)) begin
                        s_d.state = SEQ_BODY;
                    end else begin
                        s_d.pre_cnt = s_q.pre_cnt + 1'b1;
                    end
                end
            end
            SEQ_BODY: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_sop   = in_valid && (s_q.pos == '0) && !s_q.pre_on;
                out_eop   = in_valid && (s_q.pos == POS_W'(CELL_LEN - 1));
                if (in_valid && out_ready) begin
                    if (s_q.pos == POS_W'(CELL_LEN - 1)) begin
                        s_d.state = SEQ_IDLE;
                    end else begin
                        s_d.pos = s_q.pos + 1'b1;
                    end
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign prefix_phase = (s_q.state == SEQ_PREFIX);
    assign hec_slot     = (s_q.state == SEQ_BODY) && s_q.hec_on
                          && (s_q.pos == POS_W'(HEC_SLOT));

    cpi_desc_fetch #(
        .DATA_W (DATA_W),
        .AW     (DESC_AW),
        .NUSER  (USER_BYTES)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_start),
        .first_idx  (fetch_first),
        .last_idx   (fetch_last),
        .base       (steer),
        .rd_en      (desc_rd_en),
        .rd_addr    (desc_rd_addr),
        .rd_data    (desc_rd_data),
        .done       (fetch_done),
        .user_bytes (user_bytes)
    );

    cpi_out_mux #(
        .DATA_W (DATA_W),
        .NUSER  (USER_BYTES)
    ) u_mux (
        .prefix_phase (prefix_phase),
        .prefix_idx   (s_q.pre_cnt),
        .hec_slot     (hec_slot),
        .user_bytes   (user_bytes),
        .in_data      (in_data),
        .out_data     (out_data)
    );

endmodule

// File: rtl/cpi_checker.sv
module cpi_checker (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic desc_rd_en,
    input logic out_valid,
    input logic out_sop,
    input logic out_eop,
    input logic out_ready,
    input logic [7:0] out_data
);

    // R7: a stalled output byte stays put
    a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                      && $stable(out_sop) && $stable(out_eop)));

    // R5: descriptor reads only while input is held off
    a_r5_read_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_en |-> !in_ready);

    // R5: no output is offered during a fetch
    a_r5_read_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_en |-> !out_valid);

    // R6: markers only on valid bytes and never together
    a_r6_sop_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> (out_valid && !out_eop));

    a_r6_eop_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> out_valid);

    // R9: input is accepted only when downstream takes the byte
    a_r9_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready);

endmodule

bind cell_prefix_inserter cpi_checker u_cpi_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .desc_rd_en (desc_rd_en),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_ready  (out_ready),
    .out_data   (out_data)
);

// File: tb/test_cell_prefix_inserter.sv
module test_cell_prefix_inserter;

    localparam int NCELL = 60;
    localparam int CLEN  = 53;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_prefix = 1'b0;
    logic       en_hec_swap = 1'b0;
    logic [7:0] steer = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       desc_rd_en;
    logic [7:0] desc_rd_addr;
    logic [7:0] desc_rd_data = '0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sop;
    logic       out_eop;
    logic       out_ready = 1'b0;

    always #10 clk = ~clk;

    cell_prefix_inserter i_cell_prefix_inserter (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_prefix    (en_prefix),
        .en_hec_swap  (en_hec_swap),
        .steer        (steer),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .desc_rd_en   (desc_rd_en),
        .desc_rd_addr (desc_rd_addr),
        .desc_rd_data (desc_rd_data),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_sop      (out_sop),
        .out_eop      (out_eop),
        .out_ready    (out_ready)
    );

    logic [7:0] mem [256];

    always @(posedge clk) begin
        if (desc_rd_en) desc_rd_data <= mem[desc_rd_addr];
    end

    int tests = 0;
    int fails = 0;

    logic [9:0] exp_q[$];
    string      tag_q[$];
    int         len_q[$];
    logic [7:0] cell_b [CLEN];

    function automatic logic [9:0] pack_exp(logic sop, logic eop, logic [7:0] d);
        return {sop, eop, d};
    endfunction

    function automatic int reads_for(logic p, logic h);
        return (p ? 3 : 0) + (h ? 1 : 0);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build_cell(int k);
        logic p, h;
        logic [7:0] s;
        case (k)
            0: begin p = 0; h = 0; s = 8'd10; end
            1: begin p = 1; h = 0; s = 8'd20; end
            2: begin p = 0; h = 1; s = 8'd30; end
            3: begin p = 1; h = 1; s = 8'd254; end
            4: begin p = 1; h = 1; s = 8'd0; end
            default: begin
                p = 1'($urandom % 2);
                h = 1'($urandom % 2);
                s = 8'($urandom);
            end
        endcase
        en_prefix   = p;
        en_hec_swap = h;
        steer       = s;
        for (int j = 0; j < CLEN; j++) cell_b[j] = 8'($urandom);
        if (p) begin
            for (int i = 0; i < 3; i++) begin
                exp_q.push_back(pack_exp(i == 0, 1'b0, mem[8'(s + 8'(i))]));
                tag_q.push_back("R2");
            end
        end
        for (int j = 0; j < CLEN; j++) begin
            if (j == 4 && h) begin
                exp_q.push_back(pack_exp(1'b0, 1'b0, mem[8'(s + 8'd3)]));
                tag_q.push_back("R3");
            end else begin
                exp_q.push_back(pack_exp(j == 0 && !p, j == CLEN - 1, cell_b[j]));
                tag_q.push_back(j == 0 ? "R6" : (j == CLEN - 1 ? "R6" : "R9"));
            end
        end
        len_q.push_back(p ? CLEN + 3 : CLEN);
        exp_reads += reads_for(p, h);
    endtask

    int exp_reads = 0;
    int act_reads = 0;
    int eop_seen  = 0;
    int out_cnt   = 0;
    int r5_bad    = 0;

    initial begin
        int unsigned seed;
        int  cells_sent = 0;
        int  in_idx = 0;
        bit  offered = 0;
        bit  hold = 0;
        int  cyc = 0;
        bit  timeout = 0;
        seed = $urandom(32'h5eed_0042);
        for (int a = 0; a < 256; a++) mem[a] = 8'($urandom);

        // R1: reset state
        repeat (3) @(negedge clk);
        #8;
        check("R1 reset out_valid", out_valid, 0);
        check("R1 reset in_ready", in_ready, 0);
        check("R1 reset desc_rd_en", desc_rd_en, 0);
        check("R1 reset markers", {out_sop, out_eop}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #8;
        check("R1 idle after reset", {out_valid, in_ready, desc_rd_en}, 0);

        while (!(cells_sent == NCELL && exp_q.size() == 0)) begin
            @(negedge clk);
            cyc++;
            if (cyc > 100000) begin timeout = 1; break; end
            if (cells_sent < NCELL) begin
                if (in_idx == 0 && !offered) begin
                    build_cell(cells_sent);
                    offered = 1;
                end
                if (!hold) in_valid = ($urandom % 10) < 8;
                in_data = cell_b[in_idx];
            end else begin
                in_valid = 1'b0;
            end
            out_ready = ($urandom % 10) < 7;
            #8;
            if (desc_rd_en) begin
                act_reads++;
                if (in_ready) r5_bad++;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected byte", 1, 0);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " byte"}, {out_sop, out_eop, out_data}, e);
                end
                out_cnt++;
                if (out_eop) begin
                    eop_seen++;
                    if (len_q.size() > 0) check("R2 cell length", out_cnt, len_q.pop_front());
                    out_cnt = 0;
                end
            end
            hold = in_valid && !in_ready;
            if (in_valid && in_ready) begin
                in_idx++;
                if (in_idx == 1) begin
                    // R4: disturb configuration mid-cell
                    en_prefix   = 1'($urandom % 2);
                    en_hec_swap = 1'($urandom % 2);
                    steer       = 8'($urandom);
                end
                if (in_idx == CLEN) begin
                    in_idx = 0;
                    offered = 0;
                    cells_sent++;
                end
            end
        end

        if (timeout) check("watchdog", 1, 0);
        check("R8 descriptor read count", act_reads, exp_reads);
        check("R5 reads while accepting", r5_bad, 0);
        check("R6 end-of-cell count", eop_seen, NCELL);
        check("R4 all expected bytes seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule